// File: doc/BRIEF.md
# UART Transmit Path with Clear-to-Send Gating

This block is the transmit half of a serial port. Software-side logic pushes characters into an eight-entry queue. A serializer takes them out one at a time and sends each as an asynchronous frame on the line: a start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. Each bit is held for a fixed number of pulses of an external oversampling tick, 16 by default. The baud-rate generator that makes the tick is outside the block, and so is the receiver.

Three controls can hold back the next frame: the clear-to-send input when flow control is enabled, a forced-break control, and a transmit-disable control. None of them cuts off a frame that has already begun. Gating acts only at frame boundaries. While break is asserted the line is driven to space for as long as the control stays set. The block reports when everything has been sent, mirrors the clear-to-send level, and raises a ready condition when the queue has at least a chosen amount of free space.

Top module: `uart_tx_cts`

## Requirements
- R1: After a synchronous reset the line idles at mark (1), the all-sent status is 1, the queue is empty, and the ready condition is 1 for `thr_sel`=0.
- R2: A frame is a 0 start bit followed by the data bits, least significant first. There are 8 data bits when `char7`=0 and 7 data bits (bit 7 of the written byte ignored) when `char7`=1. Every bit lasts exactly 16 `tick16` pulses.
- R3: When `par_en`=1 a parity bit follows the last data bit. With `par_even`=1 the data bits plus parity hold an even number of ones; with `par_even`=0 they hold an odd number.
- R4: The frame ends with one stop bit at 1 when `stop2`=0 and with two stop bits at 1 when `stop2`=1.
- R5: The queue holds 8 characters and sends them in write order. A write that arrives while 8 entries are held is dropped, even if an entry is taken out in the same cycle.
- R6: `tx_rdy_irq` is 1 when the free space is at least 1 entry (`thr_sel`=0), at least 4 entries (`thr_sel`=1), or all 8 entries, that is an empty queue (`thr_sel`=2 or 3).
- R7: `all_sent` is 1 exactly when the queue is empty and no frame is being shifted out.
- R8: With `cts_en`=1 and `cts_n`=1 no new frame starts. A frame already started still completes. `cts_off` always shows the level of `cts_n`.
- R9: While `brk`=1 the line is 0, and no new frame starts.
- R10: While `tx_dis`=1 no new frame starts. A frame already started still completes.
- R11: A `fifo_flush` pulse empties the queue but lets the frame in progress finish. A flush beats a write in the same cycle.
- R12: When another character is waiting and no gate is active, the next start bit begins on the same tick that ends the last stop bit, with no idle time between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, one-cycle pulse, 16 per bit |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Character to queue |
| fifo_flush | input | 1 | Empty the queue |
| char7 | input | 1 | 0: 8 data bits, 1: 7 data bits |
| stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| par_en | input | 1 | Add a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| thr_sel | input | 2 | Free-space threshold for the ready condition |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, already synchronous to clk |
| brk | input | 1 | Force the line to space |
| tx_dis | input | 1 | Hold off new frames |
| txd | output | 1 | Serial line |
| all_sent | output | 1 | Queue and shifter both empty |
| tx_rdy_irq | output | 1 | Free-space threshold reached |
| cts_off | output | 1 | 1 while clear-to-send is inactive |

## Verification
The checker watches four things on every cycle. The queue occupancy never goes past its depth. A flush leaves the queue empty. When the shifter is idle, an active clear-to-send gate, break or disable keeps it idle into the next cycle. The line holds still between ticks and sits at mark whenever everything has been sent and break is off. Frame content and its bit order, parity polarity, stop count, drop-on-full, the threshold levels, completion of a frame that was cut across by a gate or flush, and gap-free back-to-back timing can only be shown by the bench scenarios. There, a behavioural model is compared on every clock and directed decodes read the frames off the line.

// File: rtl/uatx_pkg.sv
// Shared types and constants for the UART transmit path.
// Assumes at most 12 bits per frame: 1 start, 8 data, 1 parity, 2 stop.
package uatx_pkg;
    localparam int FRAME_W = 12;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic seven;     // 7 data bits when set
        logic two_stop;  // two stop bits when set
        logic par_en;    // parity bit present
        logic par_even;  // even parity when set, odd when clear
    } uatx_cfg_t;
endpackage

// File: rtl/uatx_fifo.sv
// Character queue of DEPTH entries with a flush.
// Assumes rd_en is raised only while count is non-zero. A write is taken
// only when the count before this cycle's read is below DEPTH. Flush wins.
module uatx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          accept;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Write acceptance uses the occupancy before any read.
    assign accept  = wr_en && (count < CW'(DEPTH)) && !flush;
    assign rd_data = mem[rptr];

    // Storage write, no reset needed for the data itself.
    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= bump(wptr);
            if (rd_en)  rptr <= bump(rptr);
            count <= count + CW'(accept) - CW'(rd_en);
        end
    end
endmodule

// File: rtl/uatx_lvl.sv
// Free-space threshold for the transmit-ready condition.
// Assumes count never exceeds DEPTH. Code 0 asks for 1 free entry,
// code 1 for half the queue, codes 2 and 3 for an empty queue.
module uatx_lvl #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = (DEPTH > 1) ? DEPTH / 2 : 1
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    sel,
    output logic          irq
);
    logic [CW-1:0] free_ent;

    assign free_ent = CW'(DEPTH) - count;

    // Compare the free space with the selected level.
    always_comb begin
        case (sel)
            2'd0:    irq = free_ent >= CW'(1);
            2'd1:    irq = free_ent >= CW'(HALF);
            default: irq = free_ent == CW'(DEPTH);
        endcase
    end
endmodule

// File: rtl/uatx_ser.sv
// Frame serializer. On load it builds the whole frame from the byte and the
// configuration, then shifts one bit out every OVS ticks, LSB first.
// Assumes load only when idle or in the cycle that last_tick is high.
module uatx_ser
    import uatx_pkg::*;
#(
    parameter int OVS   = 16,
    localparam int CNTW = (OVS > 1) ? $clog2(OVS) : 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  uatx_cfg_t cfg,
    input  logic [7:0] din,
    output logic      busy,
    output logic      last_tick,
    output logic      line
);
    logic [FRAME_W-1:0] shreg, frm;
    logic [CNTW-1:0]    tcnt;
    logic [LEN_W-1:0]   left, flen;
    logic               par;

    // Assemble the frame: start, data, optional parity, stop bits as ones.
    always_comb begin
        par      = cfg.par_even ? ^din[6:0] ^ (din[7] & ~cfg.seven)
                                : ~(^din[6:0] ^ (din[7] & ~cfg.seven));
        frm      = '1;
        frm[0]   = 1'b0;
        frm[7:1] = din[6:0];
        if (cfg.seven) begin
            frm[8] = cfg.par_en ? par : 1'b1;
        end else begin
            frm[8] = din[7];
            if (cfg.par_en) frm[9] = par;
        end
        flen = LEN_W'(10) - LEN_W'(cfg.seven) + LEN_W'(cfg.par_en)
             + LEN_W'(cfg.two_stop);
    end

    assign last_tick = busy && tick && (tcnt == CNTW'(OVS - 1))
                       && (left == LEN_W'(1));
    assign line      = busy ? shreg[0] : 1'b1;

    // Load a new frame or advance the one in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            tcnt  <= '0;
            left  <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= frm;
            tcnt  <= '0;
            left  <= flen;
            busy  <= 1'b1;
        end else if (busy && tick) begin
            if (tcnt == CNTW'(OVS - 1)) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - LEN_W'(1);
                if (left == LEN_W'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + CNTW'(1);
            end
        end
    end
endmodule

// File: rtl/uart_tx_cts.sv
// UART transmit path: queue, serializer, clear-to-send, break and disable gating.
// Assumes tick16 is a one-cycle pulse and cts_n is already synchronous to clk.
// Gates are sampled only where a new frame could begin.
module uart_tx_cts
    import uatx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OVS   = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_flush,
    input  logic       char7,
    input  logic       stop2,
    input  logic       par_en,
    input  logic       par_even,
    input  logic [1:0] thr_sel,
    input  logic       cts_en,
    input  logic       cts_n,
    input  logic       brk,
    input  logic       tx_dis,
    output logic       txd,
    output logic       all_sent,
    output logic       tx_rdy_irq,
    output logic       cts_off
);
    logic [CW-1:0] fifo_cnt;
    logic [7:0]    head;
    logic          busy, last_tick, ser_line, start, gate_ok;
    uatx_cfg_t     cfg;

    assign cfg     = '{seven: char7, two_stop: stop2, par_en: par_en, par_even: par_even};
    assign gate_ok = !tx_dis && !brk && !(cts_en && cts_n);
    assign start   = tick16 && (!busy || last_tick) && (fifo_cnt != '0) && gate_ok;

    uatx_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(start), .rd_data(head), .count(fifo_cnt)
    );

    uatx_ser #(.OVS(OVS)) u_ser (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .load(start), .cfg(cfg),
        .din(head), .busy(busy), .last_tick(last_tick), .line(ser_line)
    );

    uatx_lvl #(.DEPTH(DEPTH)) u_lvl (
        .count(fifo_cnt), .sel(thr_sel), .irq(tx_rdy_irq)
    );

    assign txd      = brk ? 1'b0 : ser_line;
    assign all_sent = (fifo_cnt == '0) && !busy;
    assign cts_off  = cts_n;
endmodule

// File: rtl/uatx_chk.sv
// Property checker for uart_tx_cts, attached with bind.
module uatx_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick16,
    input logic          brk,
    input logic          tx_dis,
    input logic          cts_en,
    input logic          cts_n,
    input logic          fifo_flush,
    input logic          txd,
    input logic          all_sent,
    input logic          busy,
    input logic [CW-1:0] fifo_cnt
);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (fifo_cnt == '0));

    // R8
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && cts_n && !busy) |=> !busy);

    // R9
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !busy) |=> !busy);

    // R10
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dis && !busy) |=> !busy);

    // R2
    line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !brk) |=> (brk || $stable(txd)));

    // R7
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_sent && !brk) |-> txd);
endmodule

bind uart_tx_cts uatx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .brk(brk), .tx_dis(tx_dis),
    .cts_en(cts_en), .cts_n(cts_n), .fifo_flush(fifo_flush), .txd(txd),
    .all_sent(all_sent), .busy(busy), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_uart_tx_cts.sv
module tb_uart_tx_cts;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int OVS   = 16;

    logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, wr_en = 1'b0, fifo_flush = 1'b0;
    logic [7:0] wr_data = '0;
    logic char7 = 0, stop2 = 0, par_en = 0, par_even = 0;
    logic [1:0] thr_sel = 0;
    logic cts_en = 0, cts_n = 0, brk = 0, tx_dis = 0;
    logic txd, all_sent, tx_rdy_irq, cts_off;

    int checks = 0, fails = 0, cyc = 0, tick_div = 1, tc = 0;

    uart_tx_cts #(.DEPTH(DEPTH), .OVS(OVS)) dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_flush(fifo_flush), .char7(char7), .stop2(stop2), .par_en(par_en),
        .par_even(par_even), .thr_sel(thr_sel), .cts_en(cts_en), .cts_n(cts_n),
        .brk(brk), .tx_dis(tx_dis), .txd(txd), .all_sent(all_sent),
        .tx_rdy_irq(tx_rdy_irq), .cts_off(cts_off)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Tick source, updated just after each rising edge.
    always @(posedge clk) begin
        #1;
        tick16 = (tc % tick_div) == 0;
        tc++;
    end

    // Behavioural reference model.
    logic [7:0] q[$];
    bit  mb = 0;
    int  mc = 0, ml = 0;
    logic [11:0] msh = '1;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete(); mb = 0; mc = 0; ml = 0; msh = '1;
        end else begin
            bit acc, last, gate, st;
            acc  = wr_en && (q.size() < DEPTH);
            last = mb && tick16 && (mc == OVS - 1) && (ml == 1);
            gate = !tx_dis && !brk && !(cts_en && cts_n);
            st   = tick16 && (!mb || last) && (q.size() > 0) && gate;
            if (mb && tick16) begin
                if (mc == OVS - 1) begin
                    mc = 0; msh = {1'b1, msh[11:1]}; ml--;
                    if (ml == 0) mb = 0;
                end else mc++;
            end
            if (st) begin
                logic [7:0] d;
                int nb, p, ones;
                d = q.pop_front();
                nb = char7 ? 7 : 8;
                msh = '1; p = 0; ones = 0;
                msh[p] = 1'b0; p++;
                for (int i = 0; i < nb; i++) begin
                    msh[p] = d[i]; p++;
                    if (d[i]) ones++;
                end
                if (par_en) begin
                    msh[p] = par_even ? (ones % 2 == 1) : (ones % 2 == 0);
                    p++;
                end
                ml = p + (stop2 ? 2 : 1);
                mb = 1; mc = 0;
            end
            if (fifo_flush) q.delete();
            else if (acc) q.push_back(wr_data);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            int freen, need;
            bit m_txd, m_irq;
            m_txd = brk ? 1'b0 : (mb ? msh[0] : 1'b1);
            freen = DEPTH - q.size();
            need  = (thr_sel == 0) ? 1 : (thr_sel == 1) ? DEPTH / 2 : DEPTH;
            m_irq = freen >= need;
            chk(txd == m_txd, "R2 R3 R4 R12 txd", txd, m_txd);
            chk(all_sent == (q.size() == 0 && !mb), "R7 all_sent", all_sent, (q.size() == 0 && !mb));
            chk(tx_rdy_irq == m_irq, "R6 tx_rdy_irq", tx_rdy_irq, m_irq);
            chk(cts_off == cts_n, "R8 cts_off", cts_off, cts_n);
        end
    end

    task automatic push(input logic [7:0] d);
        @(posedge clk); #2; wr_en = 1; wr_data = d;
        @(posedge clk); #2; wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_sent();
        int k = 0;
        @(negedge clk);
        while (!all_sent && k < 5000) begin @(negedge clk); k++; end
        chk(all_sent, "R7 wait for all_sent", all_sent, 1);
    endtask

    // Decode one frame from the line (tick every cycle).
    task automatic grab(input int nbits, output logic [11:0] bits, output int t0);
        int k = 0;
        bits = '1;
        @(negedge clk);
        while (txd !== 1'b0 && k < 5000) begin @(negedge clk); k++; end
        t0 = cyc;
        repeat (OVS / 2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i > 0) repeat (OVS) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        logic [11:0] b;
        int t0, t1, tprev;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1, "R1 txd idle", txd, 1);
        chk(all_sent == 1, "R1 all_sent", all_sent, 1);
        chk(tx_rdy_irq == 1, "R1 irq", tx_rdy_irq, 1);

        // R2 8 data bits, no parity, one stop
        push(8'hA5);
        grab(10, b, t0);
        chk(b[0] == 0, "R2 start bit", b[0], 0);
        chk(b[8:1] == 8'hA5, "R2 data 8 bits", b[8:1], 8'hA5);
        chk(b[9] == 1, "R4 one stop", b[9], 1);
        wait_sent();

        // R3 R4 7 bits, even parity, two stops; bit 7 ignored
        char7 = 1; par_en = 1; par_even = 1; stop2 = 1;
        push(8'hD7);
        grab(11, b, t0);
        chk(b[7:1] == 7'h57, "R2 data 7 bits", b[7:1], 7'h57);
        chk(b[8] == 1, "R3 even parity", b[8], 1);
        chk(b[10:9] == 2'b11, "R4 two stops", b[10:9], 3);
        idle(OVS);
        chk(txd == 1, "R4 line mark after frame", txd, 1);
        wait_sent();

        // R3 odd parity, 8 bits
        char7 = 0; par_even = 0; stop2 = 0;
        push(8'h0F);
        grab(11, b, t0);
        chk(b[8:1] == 8'h0F, "R2 data", b[8:1], 8'h0F);
        chk(b[9] == 1, "R3 odd parity", b[9], 1);
        wait_sent();
        par_en = 0;

        // R5 R6 R10 queue filling while disabled
        tx_dis = 1;
        for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
        thr_sel = 1; idle(1);
        chk(tx_rdy_irq == 1, "R6 four free at code 1", tx_rdy_irq, 1);
        thr_sel = 2; idle(1);
        chk(tx_rdy_irq == 0, "R6 not empty at code 2", tx_rdy_irq, 0);
        push(8'h14);
        thr_sel = 1; idle(1);
        chk(tx_rdy_irq == 0, "R6 three free at code 1", tx_rdy_irq, 0);
        for (int i = 5; i < 10; i++) push(8'h10 + 8'(i));
        thr_sel = 0; idle(1);
        chk(tx_rdy_irq == 0, "R5 R6 queue full", tx_rdy_irq, 0);
        idle(300);
        chk(txd == 1 && all_sent == 0, "R10 nothing sent while disabled", txd, 1);
        tx_dis = 0;
        tprev = 0;
        for (int i = 0; i < 8; i++) begin
            grab(10, b, t1);
            chk(b[8:1] == 8'h10 + 8'(i), "R5 order", b[8:1], 8'h10 + i);
            if (i > 0) chk(t1 - tprev == 10 * OVS, "R12 back to back", t1 - tprev, 10 * OVS);
            tprev = t1;
        end
        wait_sent();
        idle(200);
        chk(txd == 1, "R5 overflow writes dropped", txd, 1);

        // R10 frame in progress completes under disable
        push(8'h66);
        idle(40);
        tx_dis = 1;
        wait_sent();
        chk(all_sent == 1, "R10 frame completes", all_sent, 1);
        tx_dis = 0;

        // R8 clear-to-send gating
        cts_en = 1; cts_n = 1;
        idle(1);
        chk(cts_off == 1, "R8 cts_off high", cts_off, 1);
        push(8'h3C);
        idle(300);
        chk(txd == 1 && all_sent == 0, "R8 held by cts", txd, 1);
        cts_n = 0;
        grab(10, b, t0);
        chk(b[8:1] == 8'h3C, "R8 sent after cts", b[8:1], 8'h3C);
        chk(cts_off == 0, "R8 cts_off low", cts_off, 0);
        wait_sent();
        push(8'h11); push(8'h22);
        idle(40);
        cts_n = 1;
        idle(200);
        chk(txd == 1 && all_sent == 0, "R8 second frame held", txd, 1);
        cts_n = 0;
        grab(10, b, t0);
        chk(b[8:1] == 8'h22, "R8 first frame completed, second follows", b[8:1], 8'h22);
        wait_sent();
        cts_en = 0;

        // R9 break
        brk = 1;
        idle(1);
        chk(txd == 0, "R9 line at space", txd, 0);
        push(8'h5A);
        idle(300);
        chk(txd == 0 && all_sent == 0, "R9 no frame during break", txd, 0);
        brk = 0;
        grab(10, b, t0);
        chk(b[8:1] == 8'h5A, "R9 byte kept through break", b[8:1], 8'h5A);
        wait_sent();

        // R11 flush during a frame
        push(8'h81); push(8'h82); push(8'h83);
        @(posedge clk); #2 fifo_flush = 1;
        @(posedge clk); #2 fifo_flush = 0;
        idle(60);
        chk(all_sent == 0, "R11 frame still running", all_sent, 0);
        wait_sent();
        idle(200);
        chk(txd == 1 && all_sent == 1, "R11 nothing after flush", txd, 1);
        tx_dis = 1;
        push(8'h01);
        @(posedge clk); #2 fifo_flush = 1; wr_en = 1; wr_data = 8'h02;
        @(posedge clk); #2 fifo_flush = 0; wr_en = 0;
        thr_sel = 2; idle(1);
        chk(all_sent == 1, "R11 flush beats write", all_sent, 1);
        chk(tx_rdy_irq == 1, "R11 R6 empty after flush", tx_rdy_irq, 1);
        tx_dis = 0; thr_sel = 0;

        // R2 bit length with a slower tick
        tick_div = 3;
        push(8'h96);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        t0 = cyc;
        while (!all_sent) @(negedge clk);
        chk(cyc - t0 == 10 * OVS * 3, "R2 frame length in ticks", cyc - t0, 10 * OVS * 3);
        idle(20);
        finish_run();
    end
endmodule